// File: doc/BRIEF.md
# Varicode Character Bit Serializer

This block turns queued 7-bit ASCII text into the serial bit stream of a PSK31 transmitter. Characters are written into a 256-slot circular buffer. After a start pulse, every bit-period strobe from the modulator makes the block present one symbol bit. Each character is mapped through the standard 128-entry varicode table and sent least significant bit first. A modulator outside this block turns the bit into a phase reversal (0) or a steady carrier (1).

The code length is not fixed. Character boundaries come from a zero-run counter. A valid code never holds two adjacent zeros, so three zeros in a row after the last one bit mark the end of a character. When a boundary finds the buffer empty, the block stretches the zero run into a long idle postamble. If the buffer is still empty at the end of that postamble, the block drops its transmitting flag and stops by itself.

Top module: `varicode_serializer`

## Requirements
- R1: After reset, tx_o, bit_o and overflow_o are 0 and the text buffer is empty.
- R2: Characters are coded with the standard varicode table, among them space 0x0001, 'e' 0x0003, 't' 0x0005, CR 0x001F, 'a' 0x000D, 'E' 0x0077, 'z' 0x0157, '~' 0x03AD, NUL 0x0355 and DEL 0x02B7. Code bits leave LSB first, one per strobe. bit_o takes its new value on the clock edge where bit_stb_i is high and holds it at all other times.
- R3: A one bit clears the zero-run count. After the highest one bit of a code come exactly three zero bits, and the next strobe carries the LSB of the next buffered character.
- R4: A start_i pulse while idle raises tx_o on the next edge. The first three strobes then give 0 before the first character's bits.
- R5: If the buffer is empty at a character boundary, exactly 76 further zeros are sent. tx_o falls on the edge of the strobe that carries the 76th zero, if the buffer is still empty then.
- R6: A character written during the 76-zero idle run is held until that run completes. It is then sent, followed by the normal three-zero termination.
- R7: The buffer holds at most 255 characters. A write while it is full is dropped, and overflow_o is 1 for the single cycle after that write.
- R8: start_i while tx_o is 1 has no effect. Strobes while tx_o is 0 leave bit_o at 0.
- R9: Characters are sent in write order, and the indices wrap across the 256-slot buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write one character into the buffer |
| wr_char_i | input | 7 | ASCII character to queue |
| overflow_o | output | 1 | Pulse: last write was dropped because the buffer was full |
| start_i | input | 1 | Begin transmission when idle |
| bit_stb_i | input | 1 | One pulse per symbol bit period |
| bit_o | output | 1 | Current varicode symbol bit |
| tx_o | output | 1 | Transmission in progress |

## Verification
The bench goes after the boundary count. An off-by-one in the zero-run compare would send two or four terminating zeros and shift every later bit, and that shows in the bit-exact stream comparison. The idle postamble is timed to the strobe. A design that never restores the normal threshold after the idle run would swallow the character that arrives during the run into a 76-zero boundary. A full buffer written once more must drop the write; a design that overwrites the head would change the count of one bits sent. The pointer wrap also has to keep the characters in write order.

// File: rtl/vc_pkg.sv
package vc_pkg;
  localparam int CHAR_W = 7;
  localparam int CODE_W = 16;

  typedef logic [CHAR_W-1:0] char_t;
  typedef logic [CODE_W-1:0] code_t;

  function automatic code_t vc_lo(input logic [5:0] c);
    case (c)
      6'd0: vc_lo = 16'h355;  6'd1: vc_lo = 16'h36d;  6'd2: vc_lo = 16'h2dd;  6'd3: vc_lo = 16'h3bb;
      6'd4: vc_lo = 16'h35d;  6'd5: vc_lo = 16'h3eb;  6'd6: vc_lo = 16'h3dd;  6'd7: vc_lo = 16'h2fd;
      6'd8: vc_lo = 16'h3fd;  6'd9: vc_lo = 16'h0f7;  6'd10: vc_lo = 16'h017; 6'd11: vc_lo = 16'h3db;
      6'd12: vc_lo = 16'h2ed; 6'd13: vc_lo = 16'h01f; 6'd14: vc_lo = 16'h2bb; 6'd15: vc_lo = 16'h357;
      6'd16: vc_lo = 16'h3bd; 6'd17: vc_lo = 16'h2bd; 6'd18: vc_lo = 16'h2d7; 6'd19: vc_lo = 16'h3d7;
      6'd20: vc_lo = 16'h36b; 6'd21: vc_lo = 16'h35b; 6'd22: vc_lo = 16'h2db; 6'd23: vc_lo = 16'h3ab;
      6'd24: vc_lo = 16'h37b; 6'd25: vc_lo = 16'h2fb; 6'd26: vc_lo = 16'h3b7; 6'd27: vc_lo = 16'h2ab;
      6'd28: vc_lo = 16'h2eb; 6'd29: vc_lo = 16'h377; 6'd30: vc_lo = 16'h37d; 6'd31: vc_lo = 16'h3fb;
      6'd32: vc_lo = 16'h001; 6'd33: vc_lo = 16'h1ff; 6'd34: vc_lo = 16'h1f5; 6'd35: vc_lo = 16'h15f;
      6'd36: vc_lo = 16'h1b7; 6'd37: vc_lo = 16'h2ad; 6'd38: vc_lo = 16'h375; 6'd39: vc_lo = 16'h1fd;
      6'd40: vc_lo = 16'h0df; 6'd41: vc_lo = 16'h0ef; 6'd42: vc_lo = 16'h1ed; 6'd43: vc_lo = 16'h1f7;
      6'd44: vc_lo = 16'h057; 6'd45: vc_lo = 16'h02b; 6'd46: vc_lo = 16'h075; 6'd47: vc_lo = 16'h1eb;
      6'd48: vc_lo = 16'h0ed; 6'd49: vc_lo = 16'h0bd; 6'd50: vc_lo = 16'h0b7; 6'd51: vc_lo = 16'h0ff;
      6'd52: vc_lo = 16'h1dd; 6'd53: vc_lo = 16'h1b5; 6'd54: vc_lo = 16'h1ad; 6'd55: vc_lo = 16'h16b;
      6'd56: vc_lo = 16'h1ab; 6'd57: vc_lo = 16'h1db; 6'd58: vc_lo = 16'h0af; 6'd59: vc_lo = 16'h17b;
      6'd60: vc_lo = 16'h16f; 6'd61: vc_lo = 16'h055; 6'd62: vc_lo = 16'h1d7; default: vc_lo = 16'h3d5;
    endcase
  endfunction

  function automatic code_t vc_hi(input logic [5:0] c);
    case (c)
      6'd0: vc_hi = 16'h2f5;  6'd1: vc_hi = 16'h05f;  6'd2: vc_hi = 16'h0d7;  6'd3: vc_hi = 16'h0b5;
      6'd4: vc_hi = 16'h0ad;  6'd5: vc_hi = 16'h077;  6'd6: vc_hi = 16'h0db;  6'd7: vc_hi = 16'h0bf;
      6'd8: vc_hi = 16'h155;  6'd9: vc_hi = 16'h07f;  6'd10: vc_hi = 16'h17f; 6'd11: vc_hi = 16'h17d;
      6'd12: vc_hi = 16'h0eb; 6'd13: vc_hi = 16'h0dd; 6'd14: vc_hi = 16'h0bb; 6'd15: vc_hi = 16'h0d5;
      6'd16: vc_hi = 16'h0ab; 6'd17: vc_hi = 16'h177; 6'd18: vc_hi = 16'h0f5; 6'd19: vc_hi = 16'h07b;
      6'd20: vc_hi = 16'h05b; 6'd21: vc_hi = 16'h1d5; 6'd22: vc_hi = 16'h15b; 6'd23: vc_hi = 16'h175;
      6'd24: vc_hi = 16'h15d; 6'd25: vc_hi = 16'h1bd; 6'd26: vc_hi = 16'h2d5; 6'd27: vc_hi = 16'h1df;
      6'd28: vc_hi = 16'h1ef; 6'd29: vc_hi = 16'h1bf; 6'd30: vc_hi = 16'h3f5; 6'd31: vc_hi = 16'h16d;
      6'd32: vc_hi = 16'h3ed; 6'd33: vc_hi = 16'h00d; 6'd34: vc_hi = 16'h07d; 6'd35: vc_hi = 16'h03d;
      6'd36: vc_hi = 16'h02d; 6'd37: vc_hi = 16'h003; 6'd38: vc_hi = 16'h02f; 6'd39: vc_hi = 16'h06d;
      6'd40: vc_hi = 16'h035; 6'd41: vc_hi = 16'h00b; 6'd42: vc_hi = 16'h1af; 6'd43: vc_hi = 16'h0fd;
      6'd44: vc_hi = 16'h01b; 6'd45: vc_hi = 16'h037; 6'd46: vc_hi = 16'h00f; 6'd47: vc_hi = 16'h007;
      6'd48: vc_hi = 16'h03f; 6'd49: vc_hi = 16'h1fb; 6'd50: vc_hi = 16'h015; 6'd51: vc_hi = 16'h01d;
      6'd52: vc_hi = 16'h005; 6'd53: vc_hi = 16'h03b; 6'd54: vc_hi = 16'h06f; 6'd55: vc_hi = 16'h06b;
      6'd56: vc_hi = 16'h0fb; 6'd57: vc_hi = 16'h05d; 6'd58: vc_hi = 16'h157; 6'd59: vc_hi = 16'h3b5;
      6'd60: vc_hi = 16'h1bb; 6'd61: vc_hi = 16'h2b5; 6'd62: vc_hi = 16'h3ad; default: vc_hi = 16'h2b7;
    endcase
  endfunction
endpackage

// File: rtl/vc_txt_fifo.sv
module vc_txt_fifo #(
  parameter int PTR_W = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_en_i,
  input  vc_pkg::char_t  wr_char_i,
  input  logic           pop_i,
  output vc_pkg::char_t  head_char_o,
  output logic           empty_o,
  output logic           overflow_o
);
  localparam int DEPTH = 1 << PTR_W;

  vc_pkg::char_t     mem_q [DEPTH];
  logic [PTR_W-1:0]  head_q, tail_q;
  logic              full;

  assign empty_o     = (head_q == tail_q);
  assign full        = (PTR_W'(tail_q + 1'b1) == head_q);
  assign head_char_o = mem_q[head_q];

  always_ff @(posedge clk_i) begin
    if (wr_en_i && !full) mem_q[tail_q] <= wr_char_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q     <= '0;
      tail_q     <= '0;
      overflow_o <= 1'b0;
    end else begin
      overflow_o <= wr_en_i && full;
      if (wr_en_i && !full) tail_q <= tail_q + 1'b1;
      if (pop_i)            head_q <= head_q + 1'b1;
    end
  end

  AST_FULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && full) |=> (overflow_o && $stable(tail_q))); // R7
  AST_POP_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o); // R9
endmodule

// File: rtl/vc_code_rom.sv
module vc_code_rom (
  input  vc_pkg::char_t char_i,
  output vc_pkg::code_t code_o
);
  always_comb begin
    if (char_i[6]) code_o = vc_pkg::vc_hi(char_i[5:0]);
    else           code_o = vc_pkg::vc_lo(char_i[5:0]);
  end
endmodule

// File: rtl/vc_shifter.sv
module vc_shifter #(
  parameter int EOC_ZEROS  = 2,
  parameter int IDLE_ZEROS = 75
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          bit_stb_i,
  input  logic          empty_i,
  input  vc_pkg::code_t code_i,
  output logic          pop_o,
  output logic          bit_o,
  output logic          tx_o
);
  localparam int ZC_W = $clog2(IDLE_ZEROS + 2);
  localparam logic [ZC_W-1:0] THR_EOC  = ZC_W'(EOC_ZEROS);
  localparam logic [ZC_W-1:0] THR_IDLE = ZC_W'(IDLE_ZEROS);

  vc_pkg::code_t   code_q;
  logic [ZC_W-1:0] zc_q, thr_q;
  logic            step, boundary;

  assign step     = tx_o && bit_stb_i;
  // run length passes the threshold on this zero
  assign boundary = step && !code_q[0] && (zc_q >= thr_q);
  assign pop_o    = boundary && !empty_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      zc_q   <= '0;
      thr_q  <= THR_EOC;
      bit_o  <= 1'b0;
      tx_o   <= 1'b0;
    end else if (!tx_o) begin
      if (start_i) begin
        tx_o   <= 1'b1;
        thr_q  <= THR_EOC;
        zc_q   <= '0;
        code_q <= '0;
      end
    end else if (bit_stb_i) begin
      bit_o <= code_q[0];
      if (code_q[0]) begin
        zc_q   <= '0;
        code_q <= code_q >> 1;
      end else if (boundary) begin
        zc_q <= '0;
        if (!empty_i) begin
          code_q <= code_i;
          thr_q  <= THR_EOC;
        end else if (thr_q == THR_EOC) begin
          code_q <= '0;
          thr_q  <= THR_IDLE;
        end else begin
          code_q <= '0;
          tx_o   <= 1'b0;
        end
      end else begin
        zc_q   <= zc_q + 1'b1;
        code_q <= code_q >> 1;
      end
    end
  end

  AST_IDLE_BIT_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_o |-> !bit_o); // R8
  AST_BIT_ON_STB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_stb_i |=> $stable(bit_o)); // R2
  AST_START_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_o && start_i) |=> tx_o); // R4
  AST_STOP_ON_STB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_o) |-> ($past(bit_stb_i) && !bit_o)); // R5
  AST_ZRUN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zc_q <= THR_IDLE); // R3
endmodule

// File: rtl/varicode_serializer.sv
module varicode_serializer #(
  parameter int PTR_W      = 8,
  parameter int EOC_ZEROS  = 2,
  parameter int IDLE_ZEROS = 75
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [6:0] wr_char_i,
  output logic       overflow_o,
  input  logic       start_i,
  input  logic       bit_stb_i,
  output logic       bit_o,
  output logic       tx_o
);
  vc_pkg::char_t head_char;
  vc_pkg::code_t head_code;
  logic          empty, pop;

  vc_txt_fifo #(.PTR_W(PTR_W)) u_fifo (
    .clk_i, .rst_ni, .wr_en_i, .wr_char_i,
    .pop_i(pop), .head_char_o(head_char), .empty_o(empty), .overflow_o
  );

  vc_code_rom u_rom (.char_i(head_char), .code_o(head_code));

  vc_shifter #(.EOC_ZEROS(EOC_ZEROS), .IDLE_ZEROS(IDLE_ZEROS)) u_shift (
    .clk_i, .rst_ni, .start_i, .bit_stb_i,
    .empty_i(empty), .code_i(head_code), .pop_o(pop), .bit_o, .tx_o
  );
endmodule

// File: tb/sim_varicode_serializer.sv
module sim_varicode_serializer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, start = 1'b0, stb = 1'b0;
  logic [6:0] wr_char = '0;
  logic ovf, bit_out, tx;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  varicode_serializer u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_char_i(wr_char),
    .overflow_o(ovf), .start_i(start), .bit_stb_i(stb), .bit_o(bit_out), .tx_o(tx)
  );

  // {char, expected varicode}
  localparam logic [22:0] VEC [10] = '{
    {7'd32, 16'h0001}, {7'd101, 16'h0003}, {7'd116, 16'h0005}, {7'd13, 16'h001F},
    {7'd97, 16'h000D}, {7'd69, 16'h0077}, {7'd122, 16'h0157}, {7'd126, 16'h03AD},
    {7'd0, 16'h0355}, {7'd127, 16'h02B7}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] c);
    @(negedge clk); wr_en = 1'b1; wr_char = c;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic go();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic strobe();
    @(negedge clk); stb = 1'b1;
    @(negedge clk); stb = 1'b0;
  endtask

  task automatic expect_bit(input logic b, input string tag);
    strobe();
    chk(bit_out === b, tag, int'(bit_out), int'(b));
  endtask

  task automatic expect_code(input logic [15:0] code);
    int msb = 0;
    for (int i = 0; i < 16; i++) if (code[i]) msb = i;
    for (int i = 0; i <= msb; i++) expect_bit(code[i], "R2 code bit");
    for (int i = 0; i < 3; i++) expect_bit(1'b0, "R3 terminator");
  endtask

  task automatic expect_idle();
    for (int i = 1; i <= 76; i++) begin
      expect_bit(1'b0, "R5 idle zero");
      if (i == 75) chk(tx === 1'b1, "R5 tx held", int'(tx), 1);
    end
    chk(tx === 1'b0, "R5 tx fall", int'(tx), 0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(tx === 1'b0 && bit_out === 1'b0 && ovf === 1'b0, "R1 reset outputs",
        int'({tx, bit_out, ovf}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx === 1'b0, "R1 idle after reset", int'(tx), 0);

    // vector walk: R2 R3 R4 R9
    for (int v = 0; v < 10; v++) wr(VEC[v][22:16]);
    go();
    chk(tx === 1'b1, "R4 tx rise", int'(tx), 1);
    for (int i = 0; i < 3; i++) expect_bit(1'b0, "R4 preamble");
    for (int v = 0; v < 10; v++) begin
      if (v == 4) go(); // R8 start ignored while transmitting
      expect_code(VEC[v][15:0]);
    end
    expect_idle();
    strobe();
    strobe();
    chk(bit_out === 1'b0 && tx === 1'b0, "R8 strobe while idle", int'({tx, bit_out}), 0);

    // R6 character arriving during the idle run
    go();
    for (int i = 0; i < 3; i++) expect_bit(1'b0, "R4 preamble");
    for (int i = 0; i < 10; i++) expect_bit(1'b0, "R6 idle before write");
    wr(7'd116);
    for (int i = 0; i < 66; i++) expect_bit(1'b0, "R6 idle run kept");
    chk(tx === 1'b1, "R6 tx held", int'(tx), 1);
    expect_code(16'h0005);
    expect_idle();

    // R7 overflow, R9 wrap
    for (int i = 0; i < 255; i++) wr(7'd101);
    chk(ovf === 1'b0, "R7 no overflow at 255", int'(ovf), 0);
    wr(7'd13);
    chk(ovf === 1'b1, "R7 overflow pulse", int'(ovf), 1);
    @(negedge clk);
    chk(ovf === 1'b0, "R7 overflow one cycle", int'(ovf), 0);
    go();
    begin
      int ones = 0, n = 0;
      while (tx && n < 5000) begin
        strobe();
        n++;
        if (bit_out) ones++;
      end
      chk(ones == 510, "R7 dropped write not sent", ones, 510);
      chk(n == 1354, "R9 stream length after wrap", n, 1354);
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule